// File: doc/BRIEF.md
# Posted-Write Multiplexed-Address DRAM Controller

This controller sits between a CPU-side shared data bus and a DRAM whose address pins carry the row and the column one after the other. A CPU write is not carried out while the CPU waits. The controller copies the write data into a private holding latch and the address into an internal register, then acknowledges at once. The shared bus is therefore free for other traffic while the DRAM cycle runs in the background. The holding latch feeds only the DRAM's own data-input pins. The DRAM's data-output pins are separate, so the held data can never collide with traffic on the shared bus.

Reads are not posted. A read runs the same row-then-column sequence and acknowledges the CPU when the DRAM output has been captured. The post buffer holds one entry. While it is full, any new CPU access is held off with no acknowledge until the buffered write has gone to the DRAM. A read of the address just posted therefore always returns the new data. A down-counter requests a CAS-before-RAS refresh at a fixed interval. A pending refresh is served between accesses, ahead of CPU work, and never cuts a DRAM cycle short. Every RAS low phase is followed by a minimum RAS-high precharge.

Top module: `posted_dram_ctrl`

## Requirements
- R1: While reset is asserted, dram_ras_n, dram_cas_n and dram_we_n are 1 and cpu_ack is 0.
- R2: A write request that finds the post buffer empty is acknowledged on the cycle after the accepting clock edge, and cpu_ack is high for exactly one cycle.
- R3: On the falling edge of RAS for an access, dram_addr carries address bits [ROW_W+COL_W-1:COL_W] (the row). On the following falling edge of CAS it carries bits [COL_W-1:0] (the column).
- R4: During an access, CAS falls exactly RCD cycles after RAS falls.
- R5: A DRAM write (dram_we_n low while CAS falls) presents on dram_din the data captured at the write acknowledge, even if cpu_wdata has changed since then. No write strobe happens unless a posted write is pending.
- R6: While a posted write is pending, no new CPU access is acknowledged. A second write issued right behind a first one is acknowledged RCD+CL+2 cycles after it is presented.
- R7: A read of the address of a pending posted write waits until that write has retired and returns the newly written data.
- R8: A read issued to an idle controller with an empty buffer acknowledges RCD+CL+1 cycles after it is presented, with cpu_rdata equal to the DRAM output word at that address.
- R9: Refresh is CAS-before-RAS: CAS is already low, and dram_we_n is high, when RAS falls. Consecutive refreshes start no more than REF_INT+RCD+CL+TRP+2 cycles apart.
- R10: A refresh never interrupts an access: every refresh RAS fall is preceded by at least TRP cycles of RAS high.
- R11: Every RAS fall is preceded by at least TRP cycles with RAS high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ROW_W+COL_W | Word address |
| cpu_wdata | input | DATA_W | Write data on the shared bus |
| cpu_ack | output | 1 | One-cycle acknowledge |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ack on a read |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | DATA_W | DRAM data-in, driven from the write latch |
| dram_dout | input | DATA_W | DRAM data-out |

## Verification
The bench builds the block with a 12+12 address split, RCD=2, CL=2, TRP=2, REF_RAS=3 and a short REF_INT of 64. With this interval, refreshes collide with CPU traffic many times in a short run, so the refresh spacing and the precharge before each refresh are exercised over and over. The small RCD and CL values give exact, hand-counted latencies for the posted write, the blocked second write and the read held behind a matching posted write. Each latency measurement is started just after an observed refresh so that no refresh disturbs it. The address vectors include all-zero, all-one and maximum-column words, which exercise both halves of the address mux.

// File: rtl/posted_dram_ctrl.sv
module posted_dram_ctrl #(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 12,
  parameter int DATA_W  = 32,
  parameter int RCD     = 2,
  parameter int CL      = 2,
  parameter int TRP     = 2,
  parameter int REF_RAS = 3,
  parameter int REF_INT = 390
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cpu_req,
  input  logic                                   cpu_we,
  input  logic [ROW_W+COL_W-1:0]                 cpu_addr,
  input  logic [DATA_W-1:0]                      cpu_wdata,
  output logic                                   cpu_ack,
  output logic [DATA_W-1:0]                      cpu_rdata,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                                   dram_ras_n,
  output logic                                   dram_cas_n,
  output logic                                   dram_we_n,
  output logic [DATA_W-1:0]                      dram_din,
  input  logic [DATA_W-1:0]                      dram_dout
);
  localparam int AW   = ROW_W + COL_W;
  localparam int MA_W = ROW_W > COL_W ? ROW_W : COL_W;
  localparam int T1   = RCD > CL ? RCD : CL;
  localparam int T2   = TRP > REF_RAS ? TRP : REF_RAS;
  localparam int TMAX = T1 > T2 ? T1 : T2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(REF_INT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_PRE, S_RFC, S_RFR} st_t;

  st_t             state;
  logic [CW-1:0]   cnt;
  logic            is_wr;
  logic [AW-1:0]   cur_addr;
  logic            pend;
  logic [AW-1:0]   pend_addr;
  logic [DATA_W-1:0] wlatch;
  logic            ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic [RW-1:0]   ref_cnt;
  logic            ref_pend;

  wire take_wr = cpu_req && cpu_we && !pend && !ack_q;
  wire take_rd = cpu_req && !cpu_we && !ack_q;
  wire cnt_end = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= RW'(REF_INT - 1);
      ref_pend <= 1'b0;
    end else begin
      if (state == S_IDLE && ref_pend) ref_pend <= 1'b0;
      if (ref_cnt == '0) begin
        ref_cnt  <= RW'(REF_INT - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      is_wr     <= 1'b0;
      cur_addr  <= '0;
      pend      <= 1'b0;
      pend_addr <= '0;
      wlatch    <= '0;
      ack_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      if (take_wr) begin
        pend      <= 1'b1;
        pend_addr <= cpu_addr;
        wlatch    <= cpu_wdata;
        ack_q     <= 1'b1;
      end
      unique case (state)
        S_IDLE: begin
          if (ref_pend) begin
            state <= S_RFC;
          end else if (pend) begin
            state    <= S_ROW;
            is_wr    <= 1'b1;
            cur_addr <= pend_addr;
            cnt      <= CW'(RCD - 1);
          end else if (take_rd) begin
            state    <= S_ROW;
            is_wr    <= 1'b0;
            cur_addr <= cpu_addr;
            cnt      <= CW'(RCD - 1);
          end
        end
        S_ROW: begin
          if (cnt_end) begin
            state <= S_COL;
            cnt   <= CW'(CL - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_COL: begin
          if (cnt_end) begin
            state <= S_PRE;
            cnt   <= CW'(TRP - 1);
            if (is_wr) begin
              pend <= 1'b0;
            end else begin
              rdata_q <= dram_dout;
              ack_q   <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PRE: begin
          if (cnt_end) state <= S_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        S_RFC: begin
          state <= S_RFR;
          cnt   <= CW'(REF_RAS - 1);
        end
        S_RFR: begin
          if (cnt_end) begin
            state <= S_PRE;
            cnt   <= CW'(TRP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dram_ras_n = !(state == S_ROW || state == S_COL || state == S_RFR);
  assign dram_cas_n = !(state == S_COL || state == S_RFC || state == S_RFR);
  assign dram_we_n  = !(state == S_COL && is_wr);
  assign dram_addr  = (state == S_COL) ? MA_W'(cur_addr[COL_W-1:0])
                                       : MA_W'(cur_addr[AW-1:COL_W]);
  assign dram_din   = wlatch;
  assign cpu_ack    = ack_q;
  assign cpu_rdata  = rdata_q;

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          hi_cnt <= CW'(TRP);
    else if (!dram_ras_n) hi_cnt <= '0;
    else if (hi_cnt != CW'(TRP)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  assert_post_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !pend && !cpu_ack) |=> cpu_ack);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !cpu_ack);
  assert_ras_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> $past(!dram_ras_n));
  assert_we_posted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> pend);
  assert_precharge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt == CW'(TRP)));
  assert_cbr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> (dram_we_n && $past(!dram_cas_n)));
endmodule

// File: tb/posted_dram_ctrl_tb_top.sv
module posted_dram_ctrl_tb_top;
  localparam int ROW_W = 12, COL_W = 12, DATA_W = 32;
  localparam int RCD = 2, CL = 2, TRP = 2, REF_RAS = 3, REF_INT = 64;
  localparam int AW = ROW_W + COL_W;
  localparam int NV = 10;
  localparam logic [AW+DATA_W:0] VEC [0:NV-1] = '{
    {1'b1, 24'h000001, 32'h11111111},
    {1'b1, 24'hABC123, 32'hCAFEF00D},
    {1'b1, 24'hFFFFFF, 32'h5A5A5A5A},
    {1'b1, 24'h000FFF, 32'h0F0F0F0F},
    {1'b1, 24'h000000, 32'h80000001},
    {1'b0, 24'h000001, 32'h11111111},
    {1'b0, 24'hABC123, 32'hCAFEF00D},
    {1'b0, 24'hFFFFFF, 32'h5A5A5A5A},
    {1'b0, 24'h000FFF, 32'h0F0F0F0F},
    {1'b0, 24'h000000, 32'h80000001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ack;
  logic [DATA_W-1:0] cpu_rdata;
  logic [11:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n;
  logic [DATA_W-1:0] dram_din;
  logic [DATA_W-1:0] dram_dout = '0;

  always #4 clk = ~clk;

  posted_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .RCD(RCD),
    .CL(CL), .TRP(TRP), .REF_RAS(REF_RAS), .REF_INT(REF_INT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_din(dram_din),
    .dram_dout(dram_dout));

  int nchk = 0, nfail = 0, mchk = 0, mfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [AW-1:0] post_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] post_data = '0;

  logic [DATA_W-1:0] mem [logic [AW-1:0]];
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [11:0] row_q = '0;
  int ras_fall_cyc = 0, hi_count = 100, ref_events = 0, last_ref = -1;

  task automatic mcheck(input bit ok, input string req, input longint act, input longint exp);
    mchk++;
    if (!ok) begin
      mfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !dram_ras_n) begin
        if (!dram_cas_n) begin
          mcheck(dram_we_n == 1'b1, "R9 we_n high in refresh", dram_we_n, 1);
          if (last_ref >= 0)
            mcheck(cyc - last_ref <= REF_INT + RCD + CL + TRP + 2, "R9 refresh gap",
                   cyc - last_ref, REF_INT + RCD + CL + TRP + 2);
          mcheck(hi_count >= TRP, "R10 precharge before refresh", hi_count, TRP);
          last_ref = cyc;
          ref_events++;
        end else begin
          row_q = dram_addr;
          ras_fall_cyc = cyc;
          mcheck(hi_count >= TRP, "R11 precharge before access", hi_count, TRP);
        end
      end
      if (prev_cas && !dram_cas_n && !dram_ras_n && !prev_ras) begin
        mcheck(cyc - ras_fall_cyc == RCD, "R4 ras-to-cas delay", cyc - ras_fall_cyc, RCD);
        if (!dram_we_n) begin
          mcheck({row_q, dram_addr} == post_addr, "R3 write address mux",
                 {row_q, dram_addr}, post_addr);
          mcheck(dram_din == post_data, "R5 latched write data", dram_din, post_data);
          mem[{row_q, dram_addr}] = dram_din;
        end else begin
          mcheck({row_q, dram_addr} == rd_addr, "R3 read address mux",
                 {row_q, dram_addr}, rd_addr);
          dram_dout = mem.exists({row_q, dram_addr}) ? mem[{row_q, dram_addr}]
                                                     : ~{8'h00, row_q, dram_addr};
        end
      end
      hi_count = dram_ras_n ? hi_count + 1 : 0;
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk + mchk, nfail + mfail);
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DATA_W-1:0] d,
                        output logic [DATA_W-1:0] rd, output int lat);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (!we) rd_addr = a;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (cpu_ack) break;
    end
    rd = cpu_rdata;
    cpu_req = 1'b0;
    if (we) begin
      post_addr = a;
      post_data = d;
      cpu_wdata = 32'hBAD0BAD0 ^ DATA_W'(a);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sync_ref();
    int e;
    e = ref_events;
    while (ref_events == e) @(negedge clk);
    idle(8);
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd;
    int lat, e0;
    idle(3);
    check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high in reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    check(!cpu_ack, "R1 ack low in reset", cpu_ack, 0);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][AW+DATA_W], VEC[i][AW+DATA_W-1:DATA_W], VEC[i][DATA_W-1:0], rd, lat);
      if (!VEC[i][AW+DATA_W])
        check(rd == VEC[i][DATA_W-1:0], "R8 read data from table", rd, VEC[i][DATA_W-1:0]);
      idle(12);
    end

    sync_ref();
    access(1'b1, 24'h123456, 32'h01234567, rd, lat);
    check(lat == 1, "R2 posted write ack latency", lat, 1);
    @(negedge clk);
    check(!cpu_ack, "R2 ack is one cycle", cpu_ack, 0);
    idle(12);

    sync_ref();
    access(1'b1, 24'h2AA555, 32'hA5A5A5A5, rd, lat);
    check(lat == 1, "R6 first write posted", lat, 1);
    access(1'b1, 24'h155AAA, 32'h5AA55AA5, rd, lat);
    check(lat == RCD + CL + 2, "R6 second write held", lat, RCD + CL + 2);
    idle(12);

    sync_ref();
    access(1'b1, 24'hABC123, 32'hFEEDBEEF, rd, lat);
    access(1'b0, 24'hABC123, 32'h0, rd, lat);
    check(rd == 32'hFEEDBEEF, "R7 read sees posted data", rd, 32'hFEEDBEEF);
    check(lat == 2 * (RCD + CL) + TRP + 2, "R7 read waits for retire", lat,
          2 * (RCD + CL) + TRP + 2);
    idle(12);

    sync_ref();
    access(1'b0, 24'h2AA555, 32'h0, rd, lat);
    check(lat == RCD + CL + 1, "R8 idle read latency", lat, RCD + CL + 1);
    check(rd == 32'hA5A5A5A5, "R8 read data", rd, 32'hA5A5A5A5);
    access(1'b0, 24'h155AAA, 32'h0, rd, lat);
    check(rd == 32'h5AA55AA5, "R6 held write landed", rd, 32'h5AA55AA5);
    access(1'b0, 24'h777000, 32'h0, rd, lat);
    check(rd == ~32'h00777000, "R8 unwritten word from DRAM output", rd, ~32'h00777000);

    e0 = ref_events;
    idle(400);
    check(ref_events - e0 >= 400 / REF_INT - 1, "R9 refresh count in idle",
          ref_events - e0, 400 / REF_INT - 1);

    for (int i = 0; i < 20; i++) begin
      access(1'b1, AW'(i * 24'h010203), DATA_W'(i * 32'h01010101), rd, lat);
      access(1'b0, AW'(i * 24'h010203), 32'h0, rd, lat);
      check(rd == DATA_W'(i * 32'h01010101), "R7 write-read pair under refresh", rd,
            DATA_W'(i * 32'h01010101));
    end
    idle(20);
    check(ref_events > 0, "R10 refreshes served between accesses", ref_events, 1);

    summary();
    $finish;
  end
endmodule